// File: doc/BRIEF.md
# Byte-Write Flow-Through SRAM Core

This block is a small synchronous memory whose address, chip selects and access kind are captured at the clock edge, while read data flows straight out of the array during the following cycle with no output register. Each word is 36 bits: four 8-bit lanes plus one parity bit per lane. Two access strobes start an access. The processor strobe always opens with a read. The controller strobe may write in its opening cycle. Between strobes the access continues at the held address, and the write controls then choose between a read and a write in each cycle.

Writes are steered by a global write input, a byte-write enable and four lane selects. The data bus is split into a write-data input, a read-data output and a drive flag. The drive flag marks when the bus would be driven. It is forced low for every write cycle and follows the asynchronous output enable during reads. The lane count, lane width and depth are parameters. Burst address stepping lives elsewhere.

Top module: `sram_bytewr_core`

## Requirements
- R1: While reset is asserted, and after it is released until an access is selected, `rd_drive` is 0 and `rd_data` is all zeros.
- R2: At an edge where a write is taken and `gw_n` is 0, all four lanes and their parity bits are written from `wr_data`, whatever `bwe_n` and `bsel_n` are.
- R3: With `gw_n` 1 and `bwe_n` 0, each lane n whose `bsel_n[n]` is 0 is written. Lane n is data bits [8n+7:8n] with parity bit 32+n. All other lanes keep their contents.
- R4: With `gw_n` 1, either `bwe_n` 1 or all `bsel_n` bits 1 makes the cycle a read, and nothing in the array changes.
- R5: At an edge where `proc_stb_n` is 0 and `ce_a_n` is 0, the write inputs are ignored and the next cycle reads the new address. A write is taken only at a later edge, if the write inputs are active there.
- R6: At an edge where `ctrl_stb_n` is 0, `proc_stb_n` is 1 and the chip is selected, active write inputs write the word at `addr_i` at that edge. Inactive write inputs start a read.
- R7: In the cycle after any edge that takes a write, `rd_drive` is 0 and `rd_data` is zero, even with `oe_n` at 0.
- R8: `oe_n` acts without a clock. During a read cycle `rd_drive` equals the inverse of `oe_n`, and `rd_data` is zero while `oe_n` is 1.
- R9: In a read cycle `rd_data` carries the word stored at the captured address during that same cycle, with no extra clock of delay.
- R10: A started access with any chip enable inactive (`ce_a_n`=1, `ce_b`=0 or `ce_c_n`=1) deselects the core. Until the next strobe, `rd_drive` stays 0 and no write is taken.
- R11: `proc_stb_n` at 0 is ignored while `ce_a_n` is 1. `ctrl_stb_n` is ignored while `proc_stb_n` is 0, so the processor strobe wins and the access starts as a read.
- R12: Without a strobe, the access stays at the captured address, and a read in a later cycle returns that same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_stb_n | input | 1 | Processor access strobe, active low |
| ctrl_stb_n | input | 1 | Controller access strobe, active low |
| ce_a_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| addr_i | input | AW | Word address captured at a strobe |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wr_data | input | LANES*(LANE_W+1) | Write data: lanes in the low bits, parity bits above |
| rd_data | output | LANES*(LANE_W+1) | Read data, zero when not driven |
| rd_drive | output | 1 | Bus drive flag; 0 means high impedance |

## Verification
The properties assume that strobes, chip enables, write controls and data are stable around each rising edge, and that `oe_n` alone may change inside a cycle. They also assume that no strobe arrives while the synchronised reset is still held. The stimulus changes every input only at the falling edge. It waits several cycles after reset release before the first strobe, and moves `oe_n` mid-cycle only in the directed test of the asynchronous enable.

// File: rtl/sram_core_pkg.sv
package sram_core_pkg;
  typedef enum logic [1:0] {
    CYC_OFF = 2'd0,
    CYC_RD  = 2'd1,
    CYC_WR  = 2'd2
  } cyc_e;
endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sram_wr_decode.sv
module sram_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bsel_n,
  output logic [LANES-1:0] lane_we
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // global write overrides the byte path
    assign lane_we[g] = !gw_n || (!bwe_n && !bsel_n[g]);
  end
endmodule

// File: rtl/sram_access_seq.sv
module sram_access_seq
  import sram_core_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          proc_stb_n,
  input  logic          ctrl_stb_n,
  input  logic          ce_a_n,
  input  logic          ce_b,
  input  logic          ce_c_n,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_req,
  output cyc_e          cyc_q,
  output logic [AW-1:0] addr_q,
  output logic          wr_take,
  output logic [AW-1:0] wr_addr
);
  logic proc_go;
  logic ctrl_go;
  logic start;
  logic sel_ok;
  cyc_e cyc_d;

  always_comb begin
    proc_go = !proc_stb_n && !ce_a_n;
    ctrl_go = !ctrl_stb_n && proc_stb_n;
    start   = proc_go || ctrl_go;
    sel_ok  = !ce_a_n && ce_b && !ce_c_n;
    cyc_d   = cyc_q;
    wr_take = 1'b0;
    wr_addr = addr_q;
    if (start) begin
      wr_addr = addr_i;
      if (!sel_ok) begin
        cyc_d = CYC_OFF;
      end else if (ctrl_go && wr_req) begin
        cyc_d   = CYC_WR;
        wr_take = 1'b1;
      end else begin
        cyc_d = CYC_RD;
      end
    end else if (cyc_q != CYC_OFF) begin
      if (wr_req) begin
        cyc_d   = CYC_WR;
        wr_take = 1'b1;
      end else begin
        cyc_d = CYC_RD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= CYC_OFF;
    else        cyc_q <= cyc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (start) addr_q <= addr_i;
  end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int AW     = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                         clk,
  input  logic [LANES-1:0]             lane_we,
  input  logic [AW-1:0]                wr_addr,
  input  logic [LANES-1:0][LANE_W:0]   wr_lane,
  input  logic [AW-1:0]                rd_addr,
  output logic [LANES-1:0][LANE_W:0]   rd_lane
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[wr_addr] <= wr_lane[g];
    end

    assign rd_lane[g] = mem[rd_addr];
  end
endmodule

// File: rtl/sram_bytewr_core.sv
module sram_bytewr_core
  import sram_core_pkg::*;
#(
  parameter int AW     = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            proc_stb_n,
  input  logic                            ctrl_stb_n,
  input  logic                            ce_a_n,
  input  logic                            ce_b,
  input  logic                            ce_c_n,
  input  logic [AW-1:0]                   addr_i,
  input  logic                            gw_n,
  input  logic                            bwe_n,
  input  logic [LANES-1:0]                bsel_n,
  input  logic                            oe_n,
  input  logic [LANES*(LANE_W+1)-1:0]     wr_data,
  output logic [LANES*(LANE_W+1)-1:0]     rd_data,
  output logic                            rd_drive
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int BUS_W  = LANES * (LANE_W + 1);

  logic                       rst_sync_n;
  logic [LANES-1:0]           lane_sel;
  logic [LANES-1:0]           lane_we;
  logic                       wr_req;
  logic                       wr_take;
  cyc_e                       cyc_q;
  logic [AW-1:0]              addr_q;
  logic [AW-1:0]              wr_addr;
  logic [LANES-1:0][LANE_W:0] wr_lane;
  logic [LANES-1:0][LANE_W:0] rd_lane;
  logic [BUS_W-1:0]           rd_word;

  sram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sram_wr_decode #(.LANES(LANES)) u_dec (
    .gw_n    (gw_n),
    .bwe_n   (bwe_n),
    .bsel_n  (bsel_n),
    .lane_we (lane_sel)
  );

  assign wr_req  = |lane_sel;
  assign lane_we = lane_sel & {LANES{wr_take}};

  sram_access_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .ce_a_n     (ce_a_n),
    .ce_b       (ce_b),
    .ce_c_n     (ce_c_n),
    .addr_i     (addr_i),
    .wr_req     (wr_req),
    .cyc_q      (cyc_q),
    .addr_q     (addr_q),
    .wr_take    (wr_take),
    .wr_addr    (wr_addr)
  );

  // lane n: data bits in the low field, parity bit in the top field
  for (genvar g = 0; g < LANES; g++) begin : g_map
    assign wr_lane[g] = {wr_data[DATA_W + g], wr_data[g*LANE_W +: LANE_W]};
    assign rd_word[g*LANE_W +: LANE_W] = rd_lane[g][LANE_W-1:0];
    assign rd_word[DATA_W + g]         = rd_lane[g][LANE_W];
  end

  sram_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk     (clk),
    .lane_we (lane_we),
    .wr_addr (wr_addr),
    .wr_lane (wr_lane),
    .rd_addr (addr_q),
    .rd_lane (rd_lane)
  );

  assign rd_drive = (cyc_q == CYC_RD) && !oe_n;
  assign rd_data  = rd_drive ? rd_word : '0;
endmodule

// File: rtl/sram_bytewr_core_chk.sv
module sram_bytewr_core_chk #(
  parameter int LANES = 4,
  parameter int BUS_W = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             proc_stb_n,
  input logic             ctrl_stb_n,
  input logic             ce_a_n,
  input logic             ce_b,
  input logic             ce_c_n,
  input logic             gw_n,
  input logic             bwe_n,
  input logic [LANES-1:0] bsel_n,
  input logic             oe_n,
  input logic [BUS_W-1:0] rd_data,
  input logic             rd_drive
);
  logic sel_ok;
  assign sel_ok = !ce_a_n && ce_b && !ce_c_n;

  // R1: no drive while the core is held in reset
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!rd_drive && rd_data == '0));

  // R5: a processor-started access opens with a read
  a_r5_proc_opens_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_stb_n && sel_ok) |=> (rd_drive || oe_n));

  // R6 and R7: controller-started write floats the bus next cycle
  a_r6_ctrl_write_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_stb_n && !ctrl_stb_n && sel_ok && (!gw_n || (!bwe_n && bsel_n != '1)))
    |=> !rd_drive);

  // R10: deselecting start keeps the bus floating
  a_r10_deselect_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_stb_n && !ctrl_stb_n && !ce_b) |=> !rd_drive);

  // R8: drive only with the output enable active
  a_r8_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive |-> !oe_n);

  // R12: a held read keeps returning the same word
  a_r12_held_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(proc_stb_n) && $past(ctrl_stb_n) && $past(rd_drive) && rd_drive)
    |-> $stable(rd_data));
endmodule

bind sram_bytewr_core sram_bytewr_core_chk #(
  .LANES (LANES),
  .BUS_W (LANES * (LANE_W + 1))
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .proc_stb_n (proc_stb_n),
  .ctrl_stb_n (ctrl_stb_n),
  .ce_a_n     (ce_a_n),
  .ce_b       (ce_b),
  .ce_c_n     (ce_c_n),
  .gw_n       (gw_n),
  .bwe_n      (bwe_n),
  .bsel_n     (bsel_n),
  .oe_n       (oe_n),
  .rd_data    (rd_data),
  .rd_drive   (rd_drive)
);

// File: tb/sram_bytewr_core_test.sv
module sram_bytewr_core_test;
  localparam int AW = 4;
  localparam int LANES = 4;
  localparam int LANE_W = 8;
  localparam int BUS_W = LANES * (LANE_W + 1);
  localparam int NVEC = 18;

  typedef struct packed {
    logic             ps_n;
    logic             cs_n;
    logic             cea_n;
    logic             ceb;
    logic             cec_n;
    logic [AW-1:0]    a;
    logic             gw_n;
    logic             bwe_n;
    logic [LANES-1:0] bs_n;
    logic             oe_n;
    logic [BUS_W-1:0] wd;
    logic             exp_drv;
    logic [BUS_W-1:0] exp_rd;
    logic [15:0]      tag;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1,1'b0,1'b0,1'b1,1'b0,4'd5,1'b0,1'b1,4'hF,1'b0,36'h5_CAFEF00D,1'b0,36'h0,"R6"},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,4'd3,1'b0,1'b1,4'hF,1'b0,36'hF_11223344,1'b0,36'h0,"R2"},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,4'd0,1'b1,1'b1,4'hF,1'b0,36'h0,1'b1,36'hF_11223344,"R9"},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,4'd0,1'b1,1'b0,4'hA,1'b0,36'h0_55667788,1'b0,36'h0,"R7"},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,4'd0,1'b1,1'b1,4'hF,1'b0,36'h0,1'b1,36'hA_11663388,"R3"},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,4'd0,1'b1,1'b0,4'hF,1'b0,36'hF_FFFFFFFF,1'b1,36'hA_11663388,"R4"},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,4'd0,1'b1,1'b1,4'h0,1'b0,36'hF_FFFFFFFF,1'b1,36'hA_11663388,"R4"},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,4'd0,1'b1,1'b1,4'hF,1'b1,36'h0,1'b0,36'h0,"R8"},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,4'd5,1'b0,1'b1,4'hF,1'b0,36'h0,1'b1,36'h5_CAFEF00D,"R5"},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,4'd0,1'b0,1'b1,4'hF,1'b0,36'h3_12345678,1'b0,36'h0,"R5"},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,4'd0,1'b1,1'b1,4'hF,1'b0,36'h0,1'b1,36'h3_12345678,"R12"},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,4'd3,1'b1,1'b1,4'hF,1'b0,36'h0,1'b0,36'h0,"R10"},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,4'd0,1'b0,1'b1,4'hF,1'b0,36'h0,1'b0,36'h0,"R10"},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,4'd3,1'b1,1'b1,4'hF,1'b0,36'h0,1'b1,36'hA_11663388,"R10"},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,4'd5,1'b1,1'b1,4'hF,1'b0,36'h0,1'b1,36'hA_11663388,"R11"},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'd5,1'b0,1'b1,4'hF,1'b0,36'h0,1'b1,36'h3_12345678,"R11"},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,4'd5,1'b1,1'b0,4'h7,1'b0,36'h8_AB000000,1'b0,36'h0,"R6"},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,4'd0,1'b1,1'b1,4'hF,1'b0,36'h0,1'b1,36'hB_AB345678,"R3"}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             proc_stb_n, ctrl_stb_n, ce_a_n, ce_b, ce_c_n;
  logic [AW-1:0]    addr_i;
  logic             gw_n, bwe_n, oe_n;
  logic [LANES-1:0] bsel_n;
  logic [BUS_W-1:0] wr_data;
  logic [BUS_W-1:0] rd_data;
  logic             rd_drive;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sram_bytewr_core #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .ce_a_n     (ce_a_n),
    .ce_b       (ce_b),
    .ce_c_n     (ce_c_n),
    .addr_i     (addr_i),
    .gw_n       (gw_n),
    .bwe_n      (bwe_n),
    .bsel_n     (bsel_n),
    .oe_n       (oe_n),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .rd_drive   (rd_drive)
  );

  task automatic check_out(input logic [15:0] tag, input logic ed, input logic [BUS_W-1:0] er);
    n_chk++;
    if (rd_drive !== ed || rd_data !== er) begin
      n_bad++;
      $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h",
               tag, rd_drive, rd_data, ed, er);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic go_idle();
    proc_stb_n = 1'b1; ctrl_stb_n = 1'b1;
    ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
    addr_i = '0; gw_n = 1'b1; bwe_n = 1'b1; bsel_n = '1;
    oe_n = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    go_idle();
    repeat (3) @(negedge clk);
    check_out("R1", 1'b0, '0);          // R1 during reset, oe_n low
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_out("R1", 1'b0, '0);          // R1 after release, nothing selected

    for (int i = 0; i < NVEC; i++) begin
      proc_stb_n = VECS[i].ps_n;
      ctrl_stb_n = VECS[i].cs_n;
      ce_a_n     = VECS[i].cea_n;
      ce_b       = VECS[i].ceb;
      ce_c_n     = VECS[i].cec_n;
      addr_i     = VECS[i].a;
      gw_n       = VECS[i].gw_n;
      bwe_n      = VECS[i].bwe_n;
      bsel_n     = VECS[i].bs_n;
      oe_n       = VECS[i].oe_n;
      wr_data    = VECS[i].wd;
      @(posedge clk);
      @(negedge clk);
      check_out(VECS[i].tag, VECS[i].exp_drv, VECS[i].exp_rd);
    end

    // R8: output enable moves the drive with no clock edge (read of address 5)
    go_idle();
    @(posedge clk);
    @(negedge clk);
    check_out("R12", 1'b1, 36'hB_AB345678);
    #1 oe_n = 1'b1;
    #1 check_out("R8", 1'b0, '0);
    #1 oe_n = 1'b0;
    #1 check_out("R8", 1'b1, 36'hB_AB345678);

    // R1: reset acts at once in the middle of a read
    #1 rst_n = 1'b0;
    #1 check_out("R1", 1'b0, '0);
    @(negedge clk);
    finish_run();
  end
endmodule